// File: doc/BRIEF.md
# Stale Line Permission Table

This block sits beside a private data cache and decides whether a line that another processor has invalidated may still be read non-speculatively in its stale form. When an invalidation arrives carrying a supplanting probe, the table records the line address, the probe identifier and a countdown lifetime for that probe. A load looks the line up, and one cycle later the table answers whether the stale copy may be used.

Permission is withdrawn when any of four things happens: the probe's countdown runs out, the same probe is seen again on a later incoming message, a store-conditional touches the line, or two consecutive lookups carry the same program counter and line address, which is taken as a polling loop. A line whose cache synchronization bit is already set is never recorded. When every slot is occupied, a new invalidation evicts the slot with the least remaining lifetime and reports that line so the cache treats it as invalid.

Each slot is a small state machine with states SLOT_FREE, SLOT_LIVE and SLOT_EXPIRED. Its transitions are named: *record* (SLOT_FREE or SLOT_EXPIRED to SLOT_LIVE, or to SLOT_EXPIRED if the lifetime given is zero), *refresh* (a new invalidation for an occupied slot reloads it), *run_out* (SLOT_LIVE to SLOT_EXPIRED when the countdown leaves 1), and *drop* (SLOT_LIVE or SLOT_EXPIRED to SLOT_FREE on probe re-observation, store-conditional, polling, or a lookup that hits an expired slot). Recording wins over dropping when both fall on one slot in the same cycle.

Top module: `stale_permit_table`

## Requirements
- R1: After reset every slot is free, `rsp_valid` and `evict_valid` are 0, and any lookup answers not usable.
- R2: Every lookup (`ld_valid`=1) produces `rsp_valid`=1 on the next cycle; `rsp_usable`=1 only then, and only when the line is held in SLOT_LIVE and the lookup is not a polling repeat.
- R3: An invalidation with lifetime L recorded in cycle t makes lookups issued in cycles t+1 to t+L answer usable; a lookup in cycle t+L+1 or later answers not usable.
- R4: An observation of probe P on `obs_valid` drops every slot whose recorded probe equals P; slots with other probes stay usable.
- R5: A store-conditional on a line drops its slot; an invalidation with `inv_sync`=1, or one arriving in the same cycle as a store-conditional to the same line, is not recorded.
- R6: A lookup whose PC and address both equal those of the immediately preceding lookup answers not usable and drops the slot, so later lookups of that line also answer not usable.
- R7: A lookup that misses answers not usable; a lookup that hits an expired slot answers not usable and frees the slot, so the next new invalidation fills it without any eviction.
- R8: An invalidation for a line already held updates its probe and lifetime in place, with no eviction.
- R9: With every slot occupied, a new invalidation evicts the slot with the smallest remaining lifetime (lowest slot index on a tie), pulses `evict_valid` with that line on `evict_addr` one cycle later, and the evicted line then answers not usable.
- R10: A lookup answers from the table contents before any change made in its own cycle: a lookup of an absent line in the same cycle as its invalidation answers not usable, and the following lookup answers usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Invalidation with a probe arrives |
| inv_addr | input | ADDR_W | Line address of the invalidation |
| inv_probe | input | PROBE_W | Supplanting probe identifier |
| inv_life | input | TIMER_W | Probe lifetime in cycles |
| inv_sync | input | 1 | Cache synchronization bit of the line |
| obs_valid | input | 1 | A probe is seen on another message |
| obs_probe | input | PROBE_W | Identifier of the observed probe |
| sc_valid | input | 1 | Store-conditional touches a line |
| sc_addr | input | ADDR_W | Line address of the store-conditional |
| ld_valid | input | 1 | Load lookup |
| ld_addr | input | ADDR_W | Line address of the load |
| ld_pc | input | PC_W | Program counter of the load |
| rsp_valid | output | 1 | Lookup answer valid (one cycle after lookup) |
| rsp_usable | output | 1 | Stale copy may be read |
| evict_valid | output | 1 | A slot was evicted by an invalidation |
| evict_addr | output | ADDR_W | Line address of the evicted slot |

## Verification
A lookup and an invalidation of the same line can land in one cycle, and so can a store-conditional and an invalidation of one line. The bench drives the lookup and the invalidation together for a line that is absent and expects a not-usable answer followed by a usable one on the next lookup, which shows the lookup reads the old contents while the record still happens. It also drives a store-conditional together with an invalidation of the same line and expects the line never to become usable, showing that the synchronization rule outranks recording.

// File: rtl/slpt_pkg.sv
package slpt_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE    = 2'd0,
        SLOT_LIVE    = 2'd1,
        SLOT_EXPIRED = 2'd2
    } slot_state_e;
endpackage

// File: rtl/slpt_slot.sv
module slpt_slot
    import slpt_pkg::*;
#(
    parameter int ADDR_W  = 26,
    parameter int PROBE_W = 8,
    parameter int TIMER_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               kill,
    input  logic [ADDR_W-1:0]  new_addr,
    input  logic [PROBE_W-1:0] new_probe,
    input  logic [TIMER_W-1:0] new_life,
    output slot_state_e        state_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [PROBE_W-1:0] probe_o,
    output logic [TIMER_W-1:0] timer_o
);
    slot_state_e state_q, state_d;
    logic        life_zero;

    assign life_zero = (new_life == '0);

    // next-state selection: record/refresh beats drop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (load) state_d = life_zero ? SLOT_EXPIRED : SLOT_LIVE;
            end
            SLOT_LIVE: begin
                if (load)                      state_d = life_zero ? SLOT_EXPIRED : SLOT_LIVE;
                else if (kill)                 state_d = SLOT_FREE;
                else if (timer_o <= TIMER_W'(1)) state_d = SLOT_EXPIRED;
            end
            SLOT_EXPIRED: begin
                if (load)      state_d = life_zero ? SLOT_EXPIRED : SLOT_LIVE;
                else if (kill) state_d = SLOT_FREE;
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o  <= '0;
            probe_o <= '0;
            timer_o <= '0;
        end else if (load) begin
            addr_o  <= new_addr;
            probe_o <= new_probe;
            timer_o <= new_life;
        end else if (kill) begin
            timer_o <= '0;
        end else if (timer_o != '0) begin
            timer_o <= timer_o - TIMER_W'(1);
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/slpt_victim.sv
module slpt_victim #(
    parameter int ENTRIES = 128,
    parameter int TIMER_W = 14,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]              free_vec,
    input  logic [ENTRIES-1:0][TIMER_W-1:0] timers,
    output logic                            any_free,
    output logic [IDX_W-1:0]                free_idx,
    output logic [IDX_W-1:0]                min_idx
);
    logic [TIMER_W-1:0] best;

    // lowest-index free slot
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // smallest remaining lifetime, lowest index on a tie
    always_comb begin
        min_idx = '0;
        best    = timers[0];
        for (int i = 1; i < ENTRIES; i++) begin
            if (timers[i] < best) begin
                best    = timers[i];
                min_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/slpt_poll.sv
module slpt_poll #(
    parameter int ADDR_W = 26,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [PC_W-1:0]   ld_pc,
    output logic              poll_o
);
    logic              prev_valid;
    logic [ADDR_W-1:0] prev_addr;
    logic [PC_W-1:0]   prev_pc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_addr  <= '0;
            prev_pc    <= '0;
        end else if (ld_valid) begin
            prev_valid <= 1'b1;
            prev_addr  <= ld_addr;
            prev_pc    <= ld_pc;
        end
    end

    assign poll_o = ld_valid && prev_valid && (prev_addr == ld_addr) && (prev_pc == ld_pc);
endmodule

// File: rtl/stale_permit_table.sv
module stale_permit_table
    import slpt_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int ADDR_W  = 26,
    parameter int PC_W    = 32,
    parameter int PROBE_W = 8,
    parameter int TIMER_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inv_valid,
    input  logic [ADDR_W-1:0]  inv_addr,
    input  logic [PROBE_W-1:0] inv_probe,
    input  logic [TIMER_W-1:0] inv_life,
    input  logic               inv_sync,
    input  logic               obs_valid,
    input  logic [PROBE_W-1:0] obs_probe,
    input  logic               sc_valid,
    input  logic [ADDR_W-1:0]  sc_addr,
    input  logic               ld_valid,
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic [PC_W-1:0]    ld_pc,
    output logic               rsp_valid,
    output logic               rsp_usable,
    output logic               evict_valid,
    output logic [ADDR_W-1:0]  evict_addr
);
    localparam int IDX_W = $clog2(ENTRIES);

    slot_state_e                     slot_state [ENTRIES];
    logic [ADDR_W-1:0]               slot_addr  [ENTRIES];
    logic [PROBE_W-1:0]              slot_probe [ENTRIES];
    logic [ENTRIES-1:0][TIMER_W-1:0] slot_timer;

    logic [ENTRIES-1:0] load_vec, kill_vec, free_vec, live_vec;
    logic [ENTRIES-1:0] hit_ld, hit_inv;
    logic               poll, any_free, inv_hit_any, alloc_req, evict_now, ld_live;
    logic [IDX_W-1:0]   free_idx, min_idx, inv_hit_idx;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            slpt_slot #(.ADDR_W(ADDR_W), .PROBE_W(PROBE_W), .TIMER_W(TIMER_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (load_vec[g]),
                .kill      (kill_vec[g]),
                .new_addr  (inv_addr),
                .new_probe (inv_probe),
                .new_life  (inv_life),
                .state_o   (slot_state[g]),
                .addr_o    (slot_addr[g]),
                .probe_o   (slot_probe[g]),
                .timer_o   (slot_timer[g])
            );
        end
    endgenerate

    slpt_victim #(.ENTRIES(ENTRIES), .TIMER_W(TIMER_W)) u_victim (
        .free_vec (free_vec),
        .timers   (slot_timer),
        .any_free (any_free),
        .free_idx (free_idx),
        .min_idx  (min_idx)
    );

    slpt_poll #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .ld_pc    (ld_pc),
        .poll_o   (poll)
    );

    // per-slot match and drop decisions
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            free_vec[i] = (slot_state[i] == SLOT_FREE);
            live_vec[i] = (slot_state[i] == SLOT_LIVE);
            hit_ld[i]   = !free_vec[i] && (slot_addr[i] == ld_addr);
            hit_inv[i]  = !free_vec[i] && (slot_addr[i] == inv_addr);
            kill_vec[i] = (sc_valid  && !free_vec[i] && (slot_addr[i] == sc_addr))
                        | (obs_valid && !free_vec[i] && (slot_probe[i] == obs_probe))
                        | (ld_valid  && hit_ld[i] && (!live_vec[i] || poll));
        end
    end

    // slot choice for an invalidation
    always_comb begin
        inv_hit_any = 1'b0;
        inv_hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_inv[i]) begin
                inv_hit_any = 1'b1;
                inv_hit_idx = IDX_W'(i);
            end
        end
        alloc_req = inv_valid && !inv_sync && !(sc_valid && (sc_addr == inv_addr));
        load_vec  = '0;
        evict_now = 1'b0;
        if (alloc_req) begin
            if (inv_hit_any)   load_vec[inv_hit_idx] = 1'b1;
            else if (any_free) load_vec[free_idx]    = 1'b1;
            else begin
                load_vec[min_idx] = 1'b1;
                evict_now         = 1'b1;
            end
        end
    end

    assign ld_live = |(hit_ld & live_vec);

    // output register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_usable  <= 1'b0;
            evict_valid <= 1'b0;
            evict_addr  <= '0;
        end else begin
            rsp_valid   <= ld_valid;
            rsp_usable  <= ld_valid && ld_live && !poll;
            evict_valid <= evict_now;
            if (evict_now) evict_addr <= slot_addr[min_idx];
        end
    end
endmodule

// File: rtl/slpt_checker.sv
module slpt_checker #(
    parameter int ENTRIES = 128,
    parameter int ADDR_W  = 26,
    parameter int PC_W    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               inv_valid,
    input logic               sc_valid,
    input logic [ADDR_W-1:0]  sc_addr,
    input logic               ld_valid,
    input logic [ADDR_W-1:0]  ld_addr,
    input logic [PC_W-1:0]    ld_pc,
    input logic               rsp_valid,
    input logic               rsp_usable,
    input logic               evict_valid,
    input logic [ENTRIES-1:0] load_vec
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2
    rsp_follows_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> rsp_valid);

    // R2
    usable_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_usable |-> rsp_valid);

    // R6
    polling_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ld_valid && $past(ld_valid) && (ld_addr == $past(ld_addr))
         && (ld_pc == $past(ld_pc))) |=> !rsp_usable);

    // R5
    sc_line_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ld_valid && $past(sc_valid) && (ld_addr == $past(sc_addr)))
        |=> !rsp_usable);

    // R9
    evict_needs_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && evict_valid) |-> $past(inv_valid));

    // R9
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_vec));
endmodule

bind stale_permit_table slpt_checker #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .PC_W    (PC_W)
) u_slpt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .inv_valid   (inv_valid),
    .sc_valid    (sc_valid),
    .sc_addr     (sc_addr),
    .ld_valid    (ld_valid),
    .ld_addr     (ld_addr),
    .ld_pc       (ld_pc),
    .rsp_valid   (rsp_valid),
    .rsp_usable  (rsp_usable),
    .evict_valid (evict_valid),
    .load_vec    (load_vec)
);

// File: tb/stale_permit_table_bench.sv
module stale_permit_table_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 128;
    localparam int ADDR_W  = 26;
    localparam int PC_W    = 32;
    localparam int PROBE_W = 8;
    localparam int TIMER_W = 14;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               inv_valid = 1'b0, inv_sync = 1'b0;
    logic [ADDR_W-1:0]  inv_addr = '0;
    logic [PROBE_W-1:0] inv_probe = '0;
    logic [TIMER_W-1:0] inv_life = '0;
    logic               obs_valid = 1'b0;
    logic [PROBE_W-1:0] obs_probe = '0;
    logic               sc_valid = 1'b0;
    logic [ADDR_W-1:0]  sc_addr = '0;
    logic               ld_valid = 1'b0;
    logic [ADDR_W-1:0]  ld_addr = '0;
    logic [PC_W-1:0]    ld_pc = '0;
    logic               rsp_valid, rsp_usable, evict_valid;
    logic [ADDR_W-1:0]  evict_addr;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;
    bit  rv, ru;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stale_permit_table #(
        .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PC_W(PC_W),
        .PROBE_W(PROBE_W), .TIMER_W(TIMER_W)
    ) u_stale_permit_table (
        .clk(clk), .rst_n(rst_n),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_probe(inv_probe),
        .inv_life(inv_life), .inv_sync(inv_sync),
        .obs_valid(obs_valid), .obs_probe(obs_probe),
        .sc_valid(sc_valid), .sc_addr(sc_addr),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_pc(ld_pc),
        .rsp_valid(rsp_valid), .rsp_usable(rsp_usable),
        .evict_valid(evict_valid), .evict_addr(evict_addr)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic inv(input logic [ADDR_W-1:0] a, input logic [PROBE_W-1:0] p,
                       input int life, input bit sync);
        inv_valid = 1'b1; inv_addr = a; inv_probe = p;
        inv_life = TIMER_W'(life); inv_sync = sync;
        @(negedge clk);
        inv_valid = 1'b0; inv_sync = 1'b0;
    endtask

    task automatic lookup(input logic [ADDR_W-1:0] a, input logic [PC_W-1:0] pc,
                          output bit v, output bit u);
        ld_valid = 1'b1; ld_addr = a; ld_pc = pc;
        @(negedge clk);
        ld_valid = 1'b0;
        v = rsp_valid; u = rsp_usable;
    endtask

    task automatic expect_look(input logic [ADDR_W-1:0] a, input logic [PC_W-1:0] pc,
                               input bit exp_u, input string req);
        bit v, u;
        lookup(a, pc, v, u);
        check(v == 1'b1, req, v, 1);
        check(u == exp_u, req, u, exp_u);
    endtask

    task automatic observe(input logic [PROBE_W-1:0] p);
        obs_valid = 1'b1; obs_probe = p;
        @(negedge clk);
        obs_valid = 1'b0;
    endtask

    task automatic store_cond(input logic [ADDR_W-1:0] a);
        sc_valid = 1'b1; sc_addr = a;
        @(negedge clk);
        sc_valid = 1'b0;
    endtask

    task automatic fill(input int special, input int special_life);
        for (int i = 0; i < ENTRIES; i++)
            inv(ADDR_W'(32'h100 + i), 8'h40, (i == special) ? special_life : 3000, 1'b0);
    endtask

    task automatic test_reset();
        check(rsp_valid == 1'b0, "R1", rsp_valid, 0);
        check(evict_valid == 1'b0, "R1", evict_valid, 0);
        expect_look(26'h55, 32'h1000, 1'b0, "R1");
    endtask

    task automatic test_lifetime();
        // R3: lifetime 5, usable at distance 5, not at distance 6
        inv(26'h200, 8'h01, 5, 1'b0);
        repeat (4) @(negedge clk);
        expect_look(26'h200, 32'h1100, 1'b1, "R3");
        expect_look(26'h200, 32'h1104, 1'b0, "R3");
    endtask

    task automatic test_probe_seen();
        inv(26'h300, 8'h05, 500, 1'b0);
        inv(26'h301, 8'h05, 500, 1'b0);
        inv(26'h302, 8'h06, 500, 1'b0);
        expect_look(26'h300, 32'h1200, 1'b1, "R2");
        observe(8'h05);
        expect_look(26'h300, 32'h1204, 1'b0, "R4");
        expect_look(26'h301, 32'h1208, 1'b0, "R4");
        expect_look(26'h302, 32'h120c, 1'b1, "R4");
    endtask

    task automatic test_sync();
        inv(26'h400, 8'h10, 500, 1'b0);
        store_cond(26'h400);
        expect_look(26'h400, 32'h1300, 1'b0, "R5");
        inv(26'h401, 8'h11, 500, 1'b1);
        expect_look(26'h401, 32'h1304, 1'b0, "R5");
        // store-conditional and invalidation of one line in the same cycle
        sc_valid = 1'b1; sc_addr = 26'h402;
        inv(26'h402, 8'h12, 500, 1'b0);
        sc_valid = 1'b0;
        expect_look(26'h402, 32'h1308, 1'b0, "R5");
    endtask

    task automatic test_polling();
        inv(26'h500, 8'h20, 500, 1'b0);
        expect_look(26'h500, 32'h1400, 1'b1, "R6");
        expect_look(26'h500, 32'h1400, 1'b0, "R6");
        expect_look(26'h500, 32'h1404, 1'b0, "R6");
        // same PC but another address is not polling
        inv(26'h501, 8'h21, 500, 1'b0);
        inv(26'h502, 8'h21, 500, 1'b0);
        expect_look(26'h501, 32'h1408, 1'b1, "R6");
        expect_look(26'h502, 32'h1408, 1'b1, "R6");
    endtask

    task automatic test_miss();
        expect_look(26'h3ffff, 32'h1500, 1'b0, "R7");
    endtask

    task automatic test_refresh();
        inv(26'h600, 8'h03, 3, 1'b0);
        inv(26'h600, 8'h09, 100, 1'b0);
        check(evict_valid == 1'b0, "R8", evict_valid, 0);
        repeat (10) @(negedge clk);
        expect_look(26'h600, 32'h1600, 1'b1, "R8");
        observe(8'h03);
        expect_look(26'h600, 32'h1604, 1'b1, "R8");
        observe(8'h09);
        expect_look(26'h600, 32'h1608, 1'b0, "R8");
    endtask

    task automatic test_same_cycle();
        bit v, u;
        inv_valid = 1'b1; inv_addr = 26'h700; inv_probe = 8'h30; inv_life = 14'd500;
        lookup(26'h700, 32'h1700, v, u);
        inv_valid = 1'b0;
        check(v == 1'b1, "R10", v, 1);
        check(u == 1'b0, "R10", u, 0);
        expect_look(26'h700, 32'h1704, 1'b1, "R10");
    endtask

    task automatic test_full_evict();
        do_reset();
        fill(7, 2000);
        inv(26'h999, 8'h50, 3000, 1'b0);
        check(evict_valid == 1'b1, "R9", evict_valid, 1);
        check(evict_addr == 26'h107, "R9", evict_addr, 26'h107);
        @(negedge clk);
        check(evict_valid == 1'b0, "R9", evict_valid, 0);
        expect_look(26'h107, 32'h1800, 1'b0, "R9");
        expect_look(26'h999, 32'h1804, 1'b1, "R9");
        expect_look(26'h100, 32'h1808, 1'b1, "R9");
    endtask

    task automatic test_expired_free();
        do_reset();
        fill(16, 3);
        expect_look(26'h110, 32'h1900, 1'b0, "R7");
        inv(26'h888, 8'h51, 3000, 1'b0);
        check(evict_valid == 1'b0, "R7", evict_valid, 0);
        expect_look(26'h888, 32'h1904, 1'b1, "R7");
        inv(26'h889, 8'h52, 3000, 1'b0);
        check(evict_valid == 1'b1, "R9", evict_valid, 1);
        check(evict_addr == 26'h100, "R9", evict_addr, 26'h100);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        test_reset();
        test_lifetime();
        test_probe_seen();
        test_sync();
        test_polling();
        test_miss();
        test_refresh();
        test_same_cycle();
        test_full_evict();
        test_expired_free();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule